// File: doc/BRIEF.md
# Software Generated Interrupt Router

This block turns a 64-bit write to one of three interrupt-generation registers into a delivery strobe for a set of CPU targets. A processor writes a command word that holds an interrupt ID, a routing mode, a three-level affinity prefix and a 16-bit bitmap over the lowest affinity level. The block works out which CPUs are addressed and which interrupt group the request carries, then presents the result for one cycle to the per-CPU acceptance logic downstream.

The group comes from the register that was written, the writer's security state and the distributor's security-disable bit. Each CPU's affinity is fixed at build time through a parameter table with one 32-bit word per CPU. The upper 24 bits of the word are the prefix, packed as level 3, level 2, level 1 from the top byte down. The low 8 bits are the lowest affinity level.

Top module: `sgi_router`

## Requirements
- R1: A write with `wr_sel` = 0 delivers group code 0. Group codes are: 0 = group 0, 1 = secure group 1, 2 = non-secure group 1.
- R2: A write with `wr_sel` = 1 delivers group 1 (secure) when `wr_secure` is 1 and group 2 (non-secure) when `wr_secure` is 0.
- R3: A write with `wr_sel` = 2 delivers group 2 when `wr_secure` is 1 and group 1 when `wr_secure` is 0.
- R4: When `ds_bit` is 1, a request that resolves to group 1 is delivered as group 0. Group 2 is not changed.
- R5: `sgi_ns` equals the inverse of `wr_secure` for every register select.
- R6: `sgi_id` equals `wr_data[27:24]`.
- R7: When `wr_data[40]` is 1, every CPU except `wr_cpu` is a target. Bitmap and affinity bits have no effect in this mode.
- R8: When `wr_data[40]` is 0, CPU i is a target only if `{wr_data[55:48], wr_data[39:32], wr_data[23:16]}` equals bits [31:8] of its table word and `wr_data[k]` is set, where k is the table word's bits [7:0].
- R9: A CPU whose lowest affinity value is above 15 is never a target of a bitmap-routed write, even with all 16 bitmap bits set.
- R10: The outputs are registered. `sgi_valid` and `sgi_targets` appear in the cycle after the `wr_en` cycle and last exactly one cycle. If no CPU matches, `sgi_valid` stays 0 and `sgi_targets` stays zero.
- R11: A write with `wr_sel` = 3 produces no delivery.
- R12: After reset, `sgi_valid` is 0 and `sgi_targets` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the command word |
| wr_sel | input | 2 | Register select: 0 group 0, 1 group 1 current state, 2 group 1 other state |
| wr_data | input | 64 | Command word |
| wr_secure | input | 1 | Writer is in secure state |
| wr_cpu | input | IdxW | Index of the writing CPU |
| ds_bit | input | 1 | Distributor security-disable bit |
| sgi_valid | output | 1 | Delivery strobe, one cycle |
| sgi_targets | output | NUM_CPU | Target CPU vector |
| sgi_group | output | 2 | Resolved group code |
| sgi_id | output | 4 | Interrupt ID |
| sgi_ns | output | 1 | Non-secure flag sent with the delivery |

## Verification
The assertions check on every cycle that a strobe only follows a write, that the target vector is empty whenever no strobe is raised, and that a broadcast never selects its sender. They also check that the non-secure flag inverts the writer's state, that a group 0 select yields group 0, and that the security-disable bit never lets a secure group 1 code out. Which CPUs a bitmap-routed write reaches depends on the affinity table, so only the bench's scenarios show it. The same holds for the exclusion of lowest-level values above 15 and for the full mapping from select and security state to group.

// File: rtl/sgi_router.sv
module sgi_router #(
  parameter int NUM_CPU = 8,
  localparam int IdxW = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  parameter logic [NUM_CPU*32-1:0] AFF_TABLE = {
    32'h0A0B0C10, 32'h0A0B0C0F, 32'h0A0B0C05, 32'h0A0B0C00,
    32'h00000003, 32'h00000002, 32'h00000001, 32'h00000000}
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [63:0]         wr_data,
  input  logic                wr_secure,
  input  logic [IdxW-1:0]     wr_cpu,
  input  logic                ds_bit,
  output logic                sgi_valid,
  output logic [NUM_CPU-1:0]  sgi_targets,
  output logic [1:0]          sgi_group,
  output logic [3:0]          sgi_id,
  output logic                sgi_ns
);

  localparam logic [1:0] GrpZero = 2'd0;
  localparam logic [1:0] GrpSec1 = 2'd1;
  localparam logic [1:0] GrpNs1  = 2'd2;

  wire [23:0] prefix = {wr_data[55:48], wr_data[39:32], wr_data[23:16]};
  wire        bcast  = wr_data[40];
  wire        sel_ok = (wr_sel != 2'd3);

  logic [NUM_CPU-1:0] hit;

  for (genvar i = 0; i < NUM_CPU; i++) begin : g_cpu
    localparam logic [23:0] CpuPre = AFF_TABLE[i*32+8 +: 24];
    localparam logic [7:0]  CpuLow = AFF_TABLE[i*32 +: 8];
    localparam bit          InMap  = (CpuLow <= 8'd15);
    wire direct_hit = InMap && (prefix == CpuPre) && wr_data[CpuLow[3:0]];
    assign hit[i] = bcast ? (wr_cpu != IdxW'(i)) : direct_hit;
  end

  logic [1:0] grp_raw;
  always_comb begin
    case (wr_sel)
      2'd1:    grp_raw = wr_secure ? GrpSec1 : GrpNs1;
      2'd2:    grp_raw = wr_secure ? GrpNs1 : GrpSec1;
      default: grp_raw = GrpZero;
    endcase
  end

  wire [1:0] grp = (ds_bit && grp_raw == GrpSec1) ? GrpZero : grp_raw;
  wire       fire = wr_en && sel_ok && (|hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sgi_valid   <= 1'b0;
      sgi_targets <= '0;
      sgi_group   <= GrpZero;
      sgi_id      <= 4'd0;
      sgi_ns      <= 1'b0;
    end else begin
      sgi_valid   <= fire;
      sgi_targets <= fire ? hit : '0;
      if (fire) begin
        sgi_group <= grp;
        sgi_id    <= wr_data[27:24];
        sgi_ns    <= ~wr_secure;
      end
    end
  end

endmodule

// File: rtl/sgi_router_chk.sv
module sgi_router_chk #(
  parameter int NUM_CPU = 8,
  localparam int IdxW = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [1:0]         wr_sel,
  input logic [63:0]        wr_data,
  input logic               wr_secure,
  input logic [IdxW-1:0]    wr_cpu,
  input logic               ds_bit,
  input logic               sgi_valid,
  input logic [NUM_CPU-1:0] sgi_targets,
  input logic [1:0]         sgi_group,
  input logic               sgi_ns
);

  a_r10_strobe_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    sgi_valid |-> $past(wr_en));

  a_r10_empty_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !sgi_valid |-> (sgi_targets == '0));

  a_r11_reserved_select: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd3) |=> !sgi_valid);

  a_r7_skip_sender: assert property (@(posedge clk) disable iff (!rst_n)
    (sgi_valid && $past(wr_data[40])) |-> !sgi_targets[$past(wr_cpu)]);

  a_r1_group_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sgi_valid && $past(wr_sel) == 2'd0) |-> (sgi_group == 2'd0));

  a_r4_no_secure_g1: assert property (@(posedge clk) disable iff (!rst_n)
    (sgi_valid && $past(ds_bit)) |-> (sgi_group != 2'd1));

  a_r5_ns_flag: assert property (@(posedge clk) disable iff (!rst_n)
    sgi_valid |-> (sgi_ns == !$past(wr_secure)));

endmodule

bind sgi_router sgi_router_chk #(.NUM_CPU(NUM_CPU)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .wr_secure(wr_secure), .wr_cpu(wr_cpu), .ds_bit(ds_bit), .sgi_valid(sgi_valid),
  .sgi_targets(sgi_targets), .sgi_group(sgi_group), .sgi_ns(sgi_ns));

// File: tb/tb_sgi_router.sv
module tb_sgi_router;
  localparam int N = 8;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [1:0]  wr_sel = 0;
  logic [63:0] wr_data = 0;
  logic        wr_secure = 0;
  logic [2:0]  wr_cpu = 0;
  logic        ds_bit = 0;
  logic        sgi_valid;
  logic [N-1:0] sgi_targets;
  logic [1:0]  sgi_group;
  logic [3:0]  sgi_id;
  logic        sgi_ns;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sgi_router #(.NUM_CPU(N), .AFF_TABLE({
    32'h0A0B0C10, 32'h0A0B0C0F, 32'h0A0B0C05, 32'h0A0B0C00,
    32'h00000003, 32'h00000002, 32'h00000001, 32'h00000000})) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .wr_secure(wr_secure), .wr_cpu(wr_cpu), .ds_bit(ds_bit), .sgi_valid(sgi_valid),
    .sgi_targets(sgi_targets), .sgi_group(sgi_group), .sgi_id(sgi_id), .sgi_ns(sgi_ns));

  function automatic logic [63:0] cmd(input logic [7:0] a3, input logic [7:0] a2,
                                      input logic [7:0] a1, input logic irm,
                                      input logic [3:0] id, input logic [15:0] list);
    return {8'h00, a3, 7'h00, irm, a2, 4'h0, id, a1, list};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one write; on return the registered outputs of that write are visible.
  task automatic issue(input logic [1:0] sel, input logic [63:0] d, input logic sec,
                       input logic [2:0] cpu, input logic ds);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = d; wr_secure = sec; wr_cpu = cpu; ds_bit = ds;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic expect_idle_next(input string req);
    @(negedge clk);
    chk(req, {31'd0, sgi_valid}, 0);
    chk(req, {24'd0, sgi_targets}, 0);
  endtask

  task automatic t_reset;
    chk("R12", {31'd0, sgi_valid}, 0);
    chk("R12", {24'd0, sgi_targets}, 0);
  endtask

  task automatic t_direct_low;
    issue(2'd0, cmd(8'h00, 8'h00, 8'h00, 1'b0, 4'd5, 16'h000B), 1'b1, 3'd7, 1'b0);
    chk("R8", {24'd0, sgi_targets}, 32'h0B);
    chk("R10", {31'd0, sgi_valid}, 1);
    chk("R1", {30'd0, sgi_group}, 0);
    chk("R6", {28'd0, sgi_id}, 5);
    chk("R5", {31'd0, sgi_ns}, 0);
    expect_idle_next("R10");
  endtask

  task automatic t_direct_high;
    issue(2'd1, cmd(8'h0A, 8'h0B, 8'h0C, 1'b0, 4'd9, 16'h8021), 1'b0, 3'd0, 1'b0);
    chk("R8", {24'd0, sgi_targets}, 32'h70);
    chk("R2", {30'd0, sgi_group}, 2);
    chk("R6", {28'd0, sgi_id}, 9);
    chk("R5", {31'd0, sgi_ns}, 1);
    issue(2'd0, cmd(8'h0A, 8'h0B, 8'h0C, 1'b0, 4'd15, 16'hFFFF), 1'b0, 3'd0, 1'b0);
    chk("R9", {24'd0, sgi_targets}, 32'h70);
    // prefix with one level wrong must miss
    issue(2'd0, cmd(8'h0A, 8'h0C, 8'h0C, 1'b0, 4'd1, 16'hFFFF), 1'b0, 3'd0, 1'b0);
    chk("R8", {31'd0, sgi_valid}, 0);
  endtask

  task automatic t_broadcast;
    issue(2'd2, cmd(8'hFF, 8'h77, 8'h33, 1'b1, 4'd3, 16'h0000), 1'b0, 3'd2, 1'b0);
    chk("R7", {24'd0, sgi_targets}, 32'hFB);
    chk("R3", {30'd0, sgi_group}, 1);
    chk("R5", {31'd0, sgi_ns}, 1);
    issue(2'd0, cmd(8'h00, 8'h00, 8'h00, 1'b1, 4'd3, 16'hFFFF), 1'b1, 3'd7, 1'b0);
    chk("R7", {24'd0, sgi_targets}, 32'h7F);
  endtask

  task automatic t_groups;
    issue(2'd1, cmd(8'h00, 8'h00, 8'h00, 1'b0, 4'd2, 16'h0001), 1'b1, 3'd1, 1'b0);
    chk("R2", {30'd0, sgi_group}, 1);
    issue(2'd1, cmd(8'h00, 8'h00, 8'h00, 1'b0, 4'd2, 16'h0001), 1'b1, 3'd1, 1'b1);
    chk("R4", {30'd0, sgi_group}, 0);
    issue(2'd2, cmd(8'h00, 8'h00, 8'h00, 1'b0, 4'd2, 16'h0001), 1'b1, 3'd1, 1'b1);
    chk("R3", {30'd0, sgi_group}, 2);
    chk("R4", {31'd0, sgi_ns}, 0);
    issue(2'd2, cmd(8'h00, 8'h00, 8'h00, 1'b0, 4'd2, 16'h0001), 1'b0, 3'd1, 1'b1);
    chk("R4", {30'd0, sgi_group}, 0);
  endtask

  task automatic t_no_match;
    issue(2'd0, cmd(8'h00, 8'h00, 8'h00, 1'b0, 4'd4, 16'h0100), 1'b0, 3'd0, 1'b0);
    chk("R10", {31'd0, sgi_valid}, 0);
    chk("R10", {24'd0, sgi_targets}, 0);
    issue(2'd3, cmd(8'h00, 8'h00, 8'h00, 1'b1, 4'd4, 16'hFFFF), 1'b0, 3'd0, 1'b0);
    chk("R11", {31'd0, sgi_valid}, 0);
    chk("R11", {24'd0, sgi_targets}, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_direct_low();
        t_direct_high();
        t_broadcast();
        t_groups();
        t_no_match();
      end
      begin
        repeat (5000) @(negedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule